// File: doc/BRIEF.md
# Expansion Bus Configuration Responder

This block lets a plug-in board announce itself on a 16-bit expansion bus with 24-bit addresses. While the board is waiting to be set up, the host reads its identity and capability bytes from the 64 KB configuration space. The block serves those reads from a 128 KB byte-organised configuration ROM. The ROM sits outside the block behind a synchronous read port with four byte lanes, so that a byte, word or long access is fetched in a single ROM cycle.

The host finishes setup with one byte write. A write to one register offset gives the board a base address on a 64 KB boundary, and the ROM then appears as a 128 KB window at that base. A write to another offset tells the board to stay off the bus for good. In both cases the block marks itself configured and emits a one-cycle pulse that passes the configuration chain to the next board. From then on it ignores further commands until the next reset.

Top module: `autocfg_responder`

## Requirements
- R1: After reset the block is unconfigured and unmapped, and `cfg_done`, `rd_valid` and `win_hit` are low.
- R2: A byte write (size code 0) with `cfg_sel` high to offset 0x48 while unconfigured does three things: it latches `bus_wdata[7:0]` as `win_base`, and it sets both `configured` and `mapped`. All of these are visible one cycle after the strobe.
- R3: A byte write with `cfg_sel` high to offset 0x4C while unconfigured sets `configured` and leaves `mapped` low. After that, `win_hit` stays low for every address.
- R4: `cfg_done` is high for exactly one cycle, the cycle in which `configured` first goes high.
- R5: Once configured, writes to 0x48 and 0x4C change nothing and raise no `cfg_done`. Only a reset clears the configured state.
- R6: The command decode looks only at `bus_addr[15:0]` and `bus_wdata[7:0]`. Word or long writes, writes to other offsets and writes with `cfg_sel` low are ignored.
- R7: A read strobe that selects the block raises `rd_valid` for one cycle, one cycle after the strobe. Size codes are 0 for byte, 1 for word and 2 for long. Size code 3, or a read that selects nothing, gives no response.
- R8: Read data is big-endian and zero-extended. The byte at the lowest offset lands in the most significant used byte. The data is `{ROM[o]}` for a byte, `{ROM[o],ROM[o+1]}` for a word and four bytes from `o` for a long. Offsets wrap modulo 128 KB.
- R9: A read with `cfg_sel` high uses the offset `bus_addr[16:0]`. This holds whether or not the block is configured.
- R10: `win_hit` is high exactly when the block is mapped and `base<<16 <= bus_addr <= (base<<16)+0x1FFFF`. A window read uses the offset `bus_addr-(base<<16)`.
- R11: A write that hits the window produces no read response and leaves the configuration outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_strobe | input | 1 | Address-valid strobe, one cycle per access |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_size | input | 2 | Access size: 0 byte, 1 word, 2 long, 3 reserved |
| bus_addr | input | 24 | Bus byte address |
| bus_wdata | input | 16 | Write data; only the low byte is decoded |
| cfg_sel | input | 1 | The host's select for the configuration space |
| rom_en | output | 1 | ROM read enable |
| rom_addr | output | 4x17 | Byte address for each ROM lane; lane i reads offset + i |
| rom_rdata | input | 4x8 | ROM data per lane, one cycle after `rom_en` |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data, right-aligned |
| win_hit | output | 1 | `bus_addr` lies inside the mapped ROM window |
| configured | output | 1 | The board has received its configuration command |
| mapped | output | 1 | The ROM window is active |
| win_base | output | 8 | Assigned base, in 64 KB units |
| cfg_done | output | 1 | One-cycle pulse that hands the chain to the next board |

## Verification
The hardest state to reach from the ports is the one after a command: the board is configured and the command registers keep getting hit. A second base write, a shut-up after a base write, and a base write after a shut-up all have to leave the latched state alone. The stimulus reaches these states with directed command sequences, including a mid-run reset that brings the shut-up path into play. Randomised window reads and hit probes then follow. They cover both window edges, the 128 KB offset wrap on long reads, and commands sent with junk in the upper address bits and upper data byte.

// File: rtl/acfg_pkg.sv
package acfg_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic       configured;
    logic       mapped;
    logic [7:0] base;
  } cfg_state_t;

endpackage

// File: rtl/acfg_rst_sync.sv
module acfg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = sync_q[STAGES-1];

endmodule

// File: rtl/acfg_cfg_ctrl.sv
module acfg_cfg_ctrl
  import acfg_pkg::*;
#(
  parameter int          OFF_W    = 16,
  parameter int          BASE_W   = 8,
  parameter logic [15:0] BASE_OFF = 16'h0048,
  parameter logic [15:0] SHUT_OFF = 16'h004C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [BASE_W-1:0] wr_byte,
  output logic              configured,
  output logic              mapped,
  output logic [BASE_W-1:0] base,
  output logic              done
);

  cfg_state_t st_q, st_d;
  logic       done_q, done_d;
  logic       st_en;
  logic       hit_base, hit_shut;

  assign hit_base = wr_stb && (wr_off == BASE_OFF[OFF_W-1:0]);
  assign hit_shut = wr_stb && (wr_off == SHUT_OFF[OFF_W-1:0]);

  always_comb begin
    st_d   = st_q;
    done_d = 1'b0;
    if (!st_q.configured) begin
      if (hit_base) begin
        st_d.configured = 1'b1;
        st_d.mapped     = 1'b1;
        st_d.base       = wr_byte;
        done_d          = 1'b1;
      end else if (hit_shut) begin
        st_d.configured = 1'b1;
        done_d          = 1'b1;
      end
    end
  end

  assign st_en = done_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      done_q <= 1'b0;
    end else begin
      if (st_en) st_q <= st_d;
      done_q <= done_d;
    end
  end

  assign configured = st_q.configured;
  assign mapped     = st_q.mapped;
  assign base       = st_q.base;
  assign done       = done_q;

  p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> configured && !$past(configured));
  p_sticky_cfg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    configured |=> configured && $stable(base) && $stable(mapped));
  p_map_implies_cfg_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mapped |-> configured);

endmodule

// File: rtl/acfg_win_dec.sv
module acfg_win_dec #(
  parameter int ADDR_W     = 24,
  parameter int ROM_AW     = 17,
  parameter int BASE_W     = 8,
  parameter int BASE_SHIFT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mapped,
  input  logic [BASE_W-1:0] base,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [ROM_AW-1:0] off
);

  localparam int PAD_W = ADDR_W + 1 - BASE_W - BASE_SHIFT;

  logic [ADDR_W:0] base_addr;
  logic [ADDR_W:0] diff;

  assign base_addr = {{PAD_W{1'b0}}, base, {BASE_SHIFT{1'b0}}};
  assign diff      = {1'b0, addr} - base_addr;
  assign hit       = mapped && !diff[ADDR_W] && (diff[ADDR_W-1:ROM_AW] == '0);
  assign off       = diff[ROM_AW-1:0];

  p_hit_needs_map_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> mapped);

endmodule

// File: rtl/acfg_rd_path.sv
module acfg_rd_path
  import acfg_pkg::*;
#(
  parameter int ROM_AW = 17,
  parameter int LANES  = 4,
  parameter int DATA_W = 8 * LANES
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rd_req,
  input  logic [ROM_AW-1:0]           rd_off,
  input  logic [1:0]                  rd_size,
  output logic                        rom_en,
  output logic [LANES-1:0][ROM_AW-1:0] rom_addr,
  input  logic [LANES-1:0][7:0]       rom_rdata,
  output logic                        rd_valid,
  output logic [DATA_W-1:0]           rd_data
);

  logic       accept;
  logic       valid_q;
  logic [1:0] size_q;

  assign accept = rd_req && (rd_size != SZ_RSVD);
  assign rom_en = accept;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rom_addr[g] = rd_off + ROM_AW'(g);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      size_q  <= '0;
    end else begin
      valid_q <= accept;
      if (accept) size_q <= rd_size;
    end
  end

  always_comb begin
    int nbytes;
    nbytes  = 1 << size_q;
    rd_data = '0;
    if (valid_q) begin
      for (int i = 0; i < LANES; i++) begin
        if (i < nbytes) rd_data[(nbytes-1-i)*8 +: 8] = rom_rdata[i];
      end
    end
  end

  assign rd_valid = valid_q;

  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rd_valid);
  p_rsvd_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_size == SZ_RSVD) |=> !rd_valid);
  p_idle_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);

endmodule

// File: rtl/autocfg_responder.sv
module autocfg_responder
  import acfg_pkg::*;
#(
  parameter int          ADDR_W     = 24,
  parameter int          BUS_DW     = 16,
  parameter int          ROM_AW     = 17,
  parameter int          LANES      = 4,
  parameter int          BASE_W     = 8,
  parameter int          BASE_SHIFT = 16,
  parameter int          OFF_W      = 16,
  parameter logic [15:0] BASE_OFF   = 16'h0048,
  parameter logic [15:0] SHUT_OFF   = 16'h004C
) (
  input  logic                         clk,
  input  logic                         arst_n,
  input  logic                         bus_strobe,
  input  logic                         bus_write,
  input  logic [1:0]                   bus_size,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [BUS_DW-1:0]            bus_wdata,
  input  logic                         cfg_sel,
  output logic                         rom_en,
  output logic [LANES-1:0][ROM_AW-1:0] rom_addr,
  input  logic [LANES-1:0][7:0]        rom_rdata,
  output logic                         rd_valid,
  output logic [8*LANES-1:0]           rd_data,
  output logic                         win_hit,
  output logic                         configured,
  output logic                         mapped,
  output logic [BASE_W-1:0]            win_base,
  output logic                         cfg_done
);

  logic              rst_n;
  logic              cfg_wr;
  logic              rd_req;
  logic [ROM_AW-1:0] win_off;
  logic [ROM_AW-1:0] rd_off;
  logic              unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[BUS_DW-1:BASE_W];

  acfg_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n  (rst_n)
  );

  assign cfg_wr = bus_strobe && bus_write && cfg_sel && (bus_size == SZ_BYTE);

  acfg_cfg_ctrl #(
    .OFF_W    (OFF_W),
    .BASE_W   (BASE_W),
    .BASE_OFF (BASE_OFF),
    .SHUT_OFF (SHUT_OFF)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_stb     (cfg_wr),
    .wr_off     (bus_addr[OFF_W-1:0]),
    .wr_byte    (bus_wdata[BASE_W-1:0]),
    .configured (configured),
    .mapped     (mapped),
    .base       (win_base),
    .done       (cfg_done)
  );

  acfg_win_dec #(
    .ADDR_W     (ADDR_W),
    .ROM_AW     (ROM_AW),
    .BASE_W     (BASE_W),
    .BASE_SHIFT (BASE_SHIFT)
  ) u_win (
    .clk    (clk),
    .rst_n  (rst_n),
    .mapped (mapped),
    .base   (win_base),
    .addr   (bus_addr),
    .hit    (win_hit),
    .off    (win_off)
  );

  assign rd_req = bus_strobe && !bus_write && (cfg_sel || win_hit);
  assign rd_off = cfg_sel ? bus_addr[ROM_AW-1:0] : win_off;

  acfg_rd_path #(
    .ROM_AW (ROM_AW),
    .LANES  (LANES)
  ) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_req    (rd_req),
    .rd_off    (rd_off),
    .rd_size   (bus_size),
    .rom_en    (rom_en),
    .rom_addr  (rom_addr),
    .rom_rdata (rom_rdata),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

  p_win_write_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe && bus_write && win_hit && !cfg_sel) |=> !rd_valid && $stable(win_base) && !cfg_done);
  p_shut_no_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (configured && !mapped) |-> !win_hit);

endmodule

// File: tb/autocfg_responder_tb.sv
module autocfg_responder_tb;

  logic                  clk = 1'b0;
  logic                  arst_n;
  logic                  bus_strobe, bus_write, cfg_sel;
  logic [1:0]            bus_size;
  logic [23:0]           bus_addr;
  logic [15:0]           bus_wdata;
  logic                  rom_en;
  logic [3:0][16:0]      rom_addr;
  logic [3:0][7:0]       rom_q;
  logic                  rd_valid, win_hit, configured, mapped, cfg_done;
  logic [31:0]           rd_data;
  logic [7:0]            win_base;

  int unsigned vectors = 0, miscompares = 0;
  bit          summary_done = 0;

  always #4 clk = ~clk;

  autocfg_responder u_dut (
    .clk(clk), .arst_n(arst_n), .bus_strobe(bus_strobe), .bus_write(bus_write),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cfg_sel(cfg_sel),
    .rom_en(rom_en), .rom_addr(rom_addr), .rom_rdata(rom_q), .rd_valid(rd_valid),
    .rd_data(rd_data), .win_hit(win_hit), .configured(configured), .mapped(mapped),
    .win_base(win_base), .cfg_done(cfg_done)
  );

  function automatic logic [7:0] romfn(input logic [16:0] a);
    logic [31:0] t;
    t = {15'b0, a};
    return (t[7:0] * 8'd37) ^ t[12:5] ^ {7'b0, t[16]} ^ 8'h6c;
  endfunction

  always_ff @(posedge clk) begin
    if (rom_en) for (int i = 0; i < 4; i++) rom_q[i] <= romfn(rom_addr[i]);
  end

  function automatic logic [31:0] exp_read(input logic [16:0] off, input logic [1:0] sz);
    logic [31:0] r;
    r = 0;
    for (int i = 0; i < (1 << sz); i++) r = (r << 8) | {24'b0, romfn(off + 17'(i))};
    return r;
  endfunction

  function automatic logic exp_hit(input logic [23:0] a, input logic m, input logic [7:0] b);
    logic [24:0] lo;
    lo = {1'b0, b, 16'b0};
    return m && ({1'b0, a} >= lo) && ({1'b0, a} <= lo + 25'h1FFFF);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!summary_done) begin
      summary_done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    end
  endtask

  task automatic idle();
    bus_strobe = 0; bus_write = 0; cfg_sel = 0; bus_size = 0;
  endtask

  // entered at a negedge; returns at the next negedge
  task automatic do_read(input string req, input logic [23:0] a, input logic [1:0] sz,
                         input logic sel, input logic ev, input logic [31:0] ed);
    bus_addr = a; bus_size = sz; cfg_sel = sel; bus_write = 0; bus_strobe = 1;
    @(negedge clk);
    idle();
    check(req, {31'b0, rd_valid}, {31'b0, ev});
    if (ev) check(req, rd_data, ed);
  endtask

  task automatic do_write(input logic [23:0] a, input logic [1:0] sz, input logic sel,
                          input logic [15:0] d);
    bus_addr = a; bus_size = sz; cfg_sel = sel; bus_wdata = d; bus_write = 1; bus_strobe = 1;
    @(negedge clk);
    idle();
  endtask

  task automatic chk_state(input string req, input logic c, input logic m,
                           input logic [7:0] b, input logic d);
    check(req, {20'b0, c, m, b, d}, {20'b0, c, m, b, d} ^ {20'b0, configured ^ c,
          mapped ^ m, win_base ^ b, cfg_done ^ d});
  endtask

  task automatic do_reset();
    arst_n = 0;
    repeat (3) @(negedge clk);
    arst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    int unsigned seed;
    logic [23:0] a;
    logic [1:0]  sz;
    seed = $urandom(32'h5EED_0A1C);
    idle(); bus_addr = 0; bus_wdata = 0; arst_n = 1;
    @(negedge clk);
    do_reset();

    // R1 reset state
    check("R1 configured", {31'b0, configured}, 0);
    check("R1 mapped", {31'b0, mapped}, 0);
    check("R1 cfg_done", {31'b0, cfg_done}, 0);
    check("R1 rd_valid", {31'b0, rd_valid}, 0);
    bus_addr = 24'h000000; #1;
    check("R1 win_hit", {31'b0, win_hit}, 0);

    // R9 R8 R7 random configuration reads
    for (int k = 0; k < 200; k++) begin
      a  = 24'($urandom);
      sz = 2'($urandom % 3);
      do_read("R9 cfg read", a, sz, 1'b1, 1'b1, exp_read(a[16:0], sz));
    end
    do_read("R8 wrap long", 24'h01FFFF, 2'd2, 1'b1, 1'b1, exp_read(17'h1FFFF, 2'd2));
    do_read("R8 wrap word", 24'h41FFFF, 2'd1, 1'b1, 1'b1, exp_read(17'h1FFFF, 2'd1));
    do_read("R7 rsvd size", 24'h000010, 2'd3, 1'b1, 1'b0, 0);
    do_read("R7 no select", 24'h000010, 2'd0, 1'b0, 1'b0, 0);

    // R6 ignored commands
    do_write(24'h000048, 2'd1, 1'b1, 16'h0033);
    chk_state("R6 word write", 0, 0, 8'h00, 0);
    do_write(24'h000049, 2'd0, 1'b1, 16'h0033);
    chk_state("R6 other offset", 0, 0, 8'h00, 0);
    do_write(24'h000048, 2'd0, 1'b0, 16'h0033);
    chk_state("R6 no cfg_sel", 0, 0, 8'h00, 0);

    // R2 R4 R6 base assignment, junk in upper address bits and upper data byte
    do_write(24'h5A0048, 2'd0, 1'b1, 16'hAB37);
    chk_state("R2 base write", 1, 1, 8'h37, 1);
    @(negedge clk);
    chk_state("R4 pulse ends", 1, 1, 8'h37, 0);

    // R5 further commands ignored
    do_write(24'h00004C, 2'd0, 1'b1, 16'h0000);
    chk_state("R5 shut after base", 1, 1, 8'h37, 0);
    do_write(24'h000048, 2'd0, 1'b1, 16'h0099);
    chk_state("R5 second base", 1, 1, 8'h37, 0);

    // R10 window edges and random probes
    bus_addr = 24'h370000; #1; check("R10 low edge", {31'b0, win_hit}, 1);
    bus_addr = 24'h38FFFF; #1; check("R10 high edge", {31'b0, win_hit}, 1);
    bus_addr = 24'h390000; #1; check("R10 above", {31'b0, win_hit}, 0);
    bus_addr = 24'h36FFFF; #1; check("R10 below", {31'b0, win_hit}, 0);
    for (int k = 0; k < 100; k++) begin
      a = 24'h340000 + 24'($urandom % 24'h80000);
      bus_addr = a; #1;
      check("R10 hit probe", {31'b0, win_hit}, {31'b0, exp_hit(a, 1'b1, 8'h37)});
    end
    @(negedge clk);
    for (int k = 0; k < 100; k++) begin
      a  = 24'h370000 + 24'($urandom % 24'h20000);
      sz = 2'($urandom % 3);
      do_read("R10 window read", a, sz, 1'b0, 1'b1, exp_read(17'(a - 24'h370000), sz));
    end
    do_read("R10 read outside", 24'h390000, 2'd0, 1'b0, 1'b0, 0);

    // R11 write into window
    do_write(24'h370010, 2'd2, 1'b0, 16'hFFFF);
    check("R11 no response", {31'b0, rd_valid}, 0);
    chk_state("R11 state kept", 1, 1, 8'h37, 0);

    // R9 configuration reads still answered
    do_read("R9 cfg after config", 24'h000100, 2'd1, 1'b1, 1'b1, exp_read(17'h00100, 2'd1));

    // R5 reset clears, then R3 shut-up path
    do_reset();
    chk_state("R5 reset clears", 0, 0, 8'h00, 0);
    do_write(24'hF0004C, 2'd0, 1'b1, 16'h0012);
    chk_state("R3 shut-up", 1, 0, 8'h00, 1);
    @(negedge clk);
    chk_state("R4 shut pulse ends", 1, 0, 8'h00, 0);
    bus_addr = 24'h370000; #1; check("R3 no hit", {31'b0, win_hit}, 0);
    bus_addr = 24'h000000; #1; check("R3 no hit zero", {31'b0, win_hit}, 0);
    @(negedge clk);
    do_write(24'h000048, 2'd0, 1'b1, 16'h0022);
    chk_state("R5 base after shut", 1, 0, 8'h00, 0);
    do_read("R7 unmapped window read", 24'h220000, 2'd0, 1'b0, 1'b0, 0);

    summary();
    $finish;
  end

endmodule